// File: doc/BRIEF.md
# Register-Mapped Mailbox Queue Pair

This block gives a processor a 32-bit register window onto two word queues. The inbound queue is filled by neighbouring logic through a push port, and the processor drains it by reading a pop window. The processor can also look at the head entry without removing it. The outbound queue is also filled through a push port. The processor only observes its status. The consuming logic drains it through a pop strobe and a head output.

Each queue packs its entries toward the head. When an entry is popped, every remaining entry moves forward one slot and the freed tail slot is loaded with the invalid marker 0xFFFF_FFFF. A status word reports the full flag, the empty flag and the occupancy. A config word holds the data-available interrupt enable and a pending flag that follows inbound occupancy. The single interrupt output is a level, high while the enable is set and inbound data waits.

Accesses take one cycle. Read data and the bad-access flag are combinational from the access inputs and the current state. State changes land on the clock edge that ends the access.

Top module: `mbx_window`

## Requirements
- R1: A read at offset 0x80, 0x84, 0x88 or 0x8C returns the inbound head and removes it. The remaining entries keep their arrival order.
- R2: A pop read while the inbound queue is empty returns 0xFFFF_FFFF and leaves the occupancy unchanged.
- R3: A read at 0x90 returns the inbound head slot without removing it. When the queue is empty, that slot holds 0xFFFF_FFFF.
- R4: A read at 0x98 returns inbound status. Bit 31 is set when the queue is full (occupancy equals DEPTH), bit 30 is set when it is empty, and bits [7:0] hold the occupancy. All other bits read 0.
- R5: A read at 0xB8 returns outbound status in the same format as R4.
- R6: A write at 0x9C updates only bit 0, the interrupt enable. A read at 0x9C returns the enable in bit 0 and inbound-not-empty in bit 4, with all other bits 0.
- R7: `irq` is high exactly when the enable is set and the inbound queue is non-empty.
- R8: Offset 0x94 reads 0 and ignores writes, with no bad-access indication.
- R9: Any other offset, including an offset that is not word aligned and a write to a read-only offset, raises `bad_access` during the access. Such a read returns 0, and such a write changes no state.
- R10: A push into a full queue is dropped. Occupancy and contents stay unchanged.
- R11: A pop and a push on the same queue in the same cycle act as pop then push. A full queue stays full, and the pushed word lands at the tail.
- R12: After reset both queues are empty, the config register is 0, and the head slots read 0xFFFF_FFFF.
- R13: `out_pop` removes the outbound head, and `out_head` shows 0xFFFF_FFFF when the outbound queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Register access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 8 | Byte offset |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the current access |
| bad_access | output | 1 | Access hit an unmapped or illegal offset |
| in_push | input | 1 | Push strobe for the inbound queue |
| in_data | input | 32 | Word pushed into the inbound queue |
| out_push | input | 1 | Push strobe for the outbound queue |
| out_data | input | 32 | Word pushed into the outbound queue |
| out_pop | input | 1 | Pop strobe for the outbound queue |
| out_head | output | 32 | Outbound head slot |
| irq | output | 1 | Data-available interrupt level |

## Verification
Two events can meet in one cycle: a processor pop read of the inbound queue and a push from the neighbouring logic into that same queue. The bench first fills the queue to DEPTH. It then drives a pop read at 0x80 together with `in_push`, and checks three things: the read returns the old head, status still reports full with level DEPTH, and draining the queue yields the remaining words followed by the newly pushed word. The same collision is also provoked on an empty queue. There the read must return the marker and the queue must then hold exactly the one pushed word.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] MARKER = 32'hFFFF_FFFF;

  typedef struct packed {
    logic pop;
    logic peek;
    logic in_stat;
    logic out_stat;
    logic cfg_rd;
    logic cfg_wr;
    logic bad;
  } acc_sel_t;

  function automatic logic [WORD_W-1:0] status_word(input int unsigned level,
                                                    input logic full,
                                                    input logic empty);
    logic [WORD_W-1:0] w;
    w        = '0;
    w[31]    = full;
    w[30]    = empty;
    w[7:0]   = level[7:0];
    return w;
  endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
(
  input  logic       valid,
  input  logic       write,
  input  logic [7:0] addr,
  output acc_sel_t   sel
);
  logic aligned;

  always_comb begin
    sel     = '0;
    aligned = (addr[1:0] == 2'b00);
    if (valid) begin
      if (!aligned) begin
        sel.bad = 1'b1;
      end else if (write) begin
        unique case (addr)
          8'h9C:   sel.cfg_wr = 1'b1;
          8'h94:   ;
          default: sel.bad = 1'b1;
        endcase
      end else begin
        unique case (addr)
          8'h80, 8'h84, 8'h88, 8'h8C: sel.pop      = 1'b1;
          8'h90:                       sel.peek     = 1'b1;
          8'h94:                       ;
          8'h98:                       sel.in_stat  = 1'b1;
          8'h9C:                       sel.cfg_rd   = 1'b1;
          8'hB8:                       sel.out_stat = 1'b1;
          default:                     sel.bad      = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/mbx_queue.sv
module mbx_queue
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  output logic [WORD_W-1:0] head,
  output logic [CW-1:0]     level,
  output logic              full,
  output logic              empty
);
  logic [WORD_W-1:0] slot_q [DEPTH];
  logic [WORD_W-1:0] slot_n [DEPTH];
  logic [CW-1:0]     cnt_q, cnt_n, cnt_mid;
  logic              pop_eff, push_eff;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign head  = slot_q[0];
  assign level = cnt_q;

  // next state: compact on pop, then append on push
  always_comb begin
    pop_eff  = pop && !empty;
    cnt_mid  = cnt_q - CW'(pop_eff);
    push_eff = push && (cnt_mid != CW'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      if (pop_eff) slot_n[i] = (i == DEPTH - 1) ? MARKER : slot_q[(i + 1) % DEPTH];
      else         slot_n[i] = slot_q[i];
      if (push_eff && (i == int'(cnt_mid))) slot_n[i] = push_data;
    end
    cnt_n = cnt_mid + CW'(push_eff);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= MARKER;
    end else begin
      cnt_q <= cnt_n;
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_n[i];
    end
  end

  p_empty_head_marker_r3: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> head == MARKER);
  p_empty_pop_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
  p_full_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && full) |=> (full && $stable(head)));
  p_pop_push_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty) |=> $stable(level));
  p_pop_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && !empty) |=> level == $past(level) - 1'b1);
endmodule

// File: rtl/mbx_window.sv
module mbx_window
  import mbx_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        acc_valid,
  input  logic        acc_write,
  input  logic [7:0]  acc_addr,
  input  logic [31:0] acc_wdata,
  output logic [31:0] acc_rdata,
  output logic        bad_access,
  input  logic        in_push,
  input  logic [31:0] in_data,
  input  logic        out_push,
  input  logic [31:0] out_data,
  input  logic        out_pop,
  output logic [31:0] out_head,
  output logic        irq
);
  logic              rst_sync1_q, rst_s_n;
  acc_sel_t          sel;
  logic [WORD_W-1:0] in_head;
  logic [CW-1:0]     in_level, out_level;
  logic              in_full, in_empty, out_full, out_empty;
  logic              en_q, en_n, en_ce;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync1_q <= 1'b0;
      rst_s_n     <= 1'b0;
    end else begin
      rst_sync1_q <= 1'b1;
      rst_s_n     <= rst_sync1_q;
    end
  end

  mbx_decode u_dec (
    .valid (acc_valid),
    .write (acc_write),
    .addr  (acc_addr),
    .sel   (sel)
  );

  mbx_queue #(.DEPTH(DEPTH)) u_inq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .push      (in_push),
    .push_data (in_data),
    .pop       (sel.pop),
    .head      (in_head),
    .level     (in_level),
    .full      (in_full),
    .empty     (in_empty)
  );

  mbx_queue #(.DEPTH(DEPTH)) u_outq (
    .clk       (clk),
    .rst_n     (rst_s_n),
    .push      (out_push),
    .push_data (out_data),
    .pop       (out_pop),
    .head      (out_head),
    .level     (out_level),
    .full      (out_full),
    .empty     (out_empty)
  );

  // config: only the enable bit is stored
  always_comb begin
    en_ce = sel.cfg_wr;
    en_n  = acc_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)   en_q <= 1'b0;
    else if (en_ce) en_q <= en_n;
  end

  assign irq        = en_q && !in_empty;
  assign bad_access = sel.bad;

  always_comb begin
    acc_rdata = '0;
    if (sel.pop)      acc_rdata = in_empty ? MARKER : in_head;
    if (sel.peek)     acc_rdata = in_head;
    if (sel.in_stat)  acc_rdata = status_word(int'(in_level), in_full, in_empty);
    if (sel.out_stat) acc_rdata = status_word(int'(out_level), out_full, out_empty);
    if (sel.cfg_rd) begin
      acc_rdata[0] = en_q;
      acc_rdata[4] = !in_empty;
    end
  end

  p_irq_off_after_clear_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sel.cfg_wr && !acc_wdata[0]) |=> !irq);
  p_irq_on_after_set_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sel.cfg_wr && acc_wdata[0] && !in_empty && !in_push) |=> irq);
  p_bad_keeps_cfg_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    bad_access |=> $stable(en_q));
  p_sel_onehot_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0({sel.pop, sel.peek, sel.in_stat, sel.out_stat, sel.cfg_rd, sel.cfg_wr, sel.bad}));
endmodule

// File: tb/mbx_window_test.sv
module mbx_window_test;
  localparam int DEPTH = 8;
  localparam logic [31:0] MK = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid, acc_write;
  logic [7:0]  acc_addr;
  logic [31:0] acc_wdata, acc_rdata;
  logic        bad_access;
  logic        in_push, out_push, out_pop;
  logic [31:0] in_data, out_data, out_head;
  logic        irq;
  int          total = 0;
  int          bad   = 0;

  always #2 clk = ~clk;  // 250 MHz

  mbx_window #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .bad_access(bad_access), .in_push(in_push), .in_data(in_data),
    .out_push(out_push), .out_data(out_data), .out_pop(out_pop),
    .out_head(out_head), .irq(irq)
  );

  // {req[3:0], op[1:0], addr[7:0], data[31:0], exp[31:0]}; op 0 push-in, 1 read, 2 write
  localparam int NV = 19;
  localparam logic [77:0] VEC [NV] = '{
    {4'd1,  2'd0, 8'h00, 32'h11, 32'h0},           // R1 fill
    {4'd1,  2'd0, 8'h00, 32'h22, 32'h0},
    {4'd1,  2'd0, 8'h00, 32'h33, 32'h0},
    {4'd4,  2'd1, 8'h98, 32'h0,  32'h0000_0003},   // R4 level 3
    {4'd3,  2'd1, 8'h90, 32'h0,  32'h11},          // R3 peek
    {4'd1,  2'd1, 8'h80, 32'h0,  32'h11},          // R1 pop
    {4'd1,  2'd1, 8'h84, 32'h0,  32'h22},
    {4'd4,  2'd1, 8'h98, 32'h0,  32'h0000_0001},   // R4
    {4'd1,  2'd1, 8'h88, 32'h0,  32'h33},
    {4'd2,  2'd1, 8'h8C, 32'h0,  MK},              // R2 empty pop
    {4'd4,  2'd1, 8'h98, 32'h0,  32'h4000_0000},   // R4 empty
    {4'd3,  2'd1, 8'h90, 32'h0,  MK},              // R3 empty peek
    {4'd6,  2'd2, 8'h9C, MK,     32'h0},           // R6 write all ones
    {4'd6,  2'd1, 8'h9C, 32'h0,  32'h0000_0001},   // R6 only enable kept
    {4'd6,  2'd0, 8'h00, 32'h44, 32'h0},
    {4'd6,  2'd1, 8'h9C, 32'h0,  32'h0000_0011},   // R6 pending bit
    {4'd5,  2'd1, 8'hB8, 32'h0,  32'h4000_0000},   // R5 outbound empty
    {4'd8,  2'd2, 8'h94, 32'h5,  32'h0},           // R8 ignored write
    {4'd8,  2'd1, 8'h80, 32'h0,  32'h44}           // R8 queue untouched
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [7:0] a, input logic [31:0] d,
                     output logic [31:0] rd, output logic bd);
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_wdata = d;
    #1 rd = acc_rdata; bd = bad_access;
    @(posedge clk); #1 acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic push_in(input logic [31:0] d);
    @(negedge clk); in_push = 1'b1; in_data = d;
    @(posedge clk); #1 in_push = 1'b0;
  endtask

  task automatic push_out(input logic [31:0] d);
    @(negedge clk); out_push = 1'b1; out_data = d;
    @(posedge clk); #1 out_push = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
    logic [31:0] r; logic b;
    acc(1'b0, a, 32'h0, r, b);
    check(r == exp && !b, req, r, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #800000;
    bad++; total++;
    $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r; logic b;
    acc_valid = 0; acc_write = 0; acc_addr = 0; acc_wdata = 0;
    in_push = 0; in_data = 0; out_push = 0; out_data = 0; out_pop = 0;
    do_reset();

    // R12 reset state
    rd_chk(8'h98, 32'h4000_0000, "R12 in status");
    rd_chk(8'hB8, 32'h4000_0000, "R12 out status");
    rd_chk(8'h9C, 32'h0, "R12 config");
    rd_chk(8'h90, MK, "R12 peek");
    #1 check(out_head == MK && !irq, "R12 out_head/irq", out_head, MK);

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq; logic [1:0] op; logic [7:0] ad; logic [31:0] dt, ex;
      {rq, op, ad, dt, ex} = VEC[i];
      if (op == 2'd0) push_in(dt);
      else begin
        acc(op == 2'd2, ad, dt, r, b);
        if (op == 2'd1) begin
          total++;
          if (r !== ex || b) begin
            bad++;
            $display("FAIL R%0d step %0d act=%h exp=%h", rq, i, r, ex);
          end
        end else check(!b, $sformatf("R%0d write step %0d", rq, i), {31'h0, b}, 32'h0);
      end
    end

    // R7 irq follows enable and occupancy
    #1 check(!irq, "R7 irq idle empty", {31'h0, irq}, 32'h0);
    push_in(32'h55);
    #1 check(irq, "R7 irq enabled+data", {31'h0, irq}, 32'h1);
    acc(1'b1, 8'h9C, 32'h0, r, b);
    #1 check(!irq, "R7 irq disabled", {31'h0, irq}, 32'h0);
    acc(1'b1, 8'h9C, 32'h1, r, b);
    rd_chk(8'h80, 32'h55, "R1 pop 55");
    #1 check(!irq, "R7 irq drops when empty", {31'h0, irq}, 32'h0);
    acc(1'b1, 8'h9C, 32'h0, r, b);

    // R9 unmapped and illegal accesses
    acc(1'b0, 8'hC0, 32'h0, r, b);
    check(b && r == 32'h0, "R9 unmapped read", r, 32'h0);
    acc(1'b0, 8'h81, 32'h0, r, b);
    check(b && r == 32'h0, "R9 unaligned read", r, 32'h0);
    acc(1'b0, 8'h94, 32'h0, r, b);
    check(!b && r == 32'h0, "R8 read 0x94", r, 32'h0);
    push_in(32'h66);
    acc(1'b1, 8'h80, 32'h1, r, b);
    check(b, "R9 write to pop window flagged", {31'h0, b}, 32'h1);
    rd_chk(8'h9C, 32'h0000_0010, "R9 write changed nothing");
    rd_chk(8'h80, 32'h66, "R9 queue kept word");

    // R10 fill past depth, R11 pop+push on full
    for (int i = 0; i <= DEPTH; i++) push_in(32'h100 + i);
    rd_chk(8'h98, 32'h8000_0000 | DEPTH, "R10 full status");
    @(negedge clk);
    acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 8'h80; in_push = 1'b1; in_data = 32'h200;
    #1 r = acc_rdata;
    @(posedge clk); #1 acc_valid = 1'b0; in_push = 1'b0;
    check(r == 32'h100, "R11 pop returns old head", r, 32'h100);
    rd_chk(8'h98, 32'h8000_0000 | DEPTH, "R11 still full");
    for (int i = 1; i < DEPTH; i++) rd_chk(8'h80, 32'h100 + i, "R10/R11 drain order");
    rd_chk(8'h80, 32'h200, "R11 pushed word at tail");
    rd_chk(8'h98, 32'h4000_0000, "R10 empty after drain");

    // R11 empty queue pop+push
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = 8'h84; in_push = 1'b1; in_data = 32'h300;
    #1 r = acc_rdata;
    @(posedge clk); #1 acc_valid = 1'b0; in_push = 1'b0;
    check(r == MK, "R2/R11 empty pop with push", r, MK);
    rd_chk(8'h98, 32'h0000_0001, "R11 one word");
    rd_chk(8'h80, 32'h300, "R11 word kept");

    // R5, R13 outbound
    for (int i = 0; i < 3; i++) push_out(32'h700 + i);
    rd_chk(8'hB8, 32'h0000_0003, "R5 out level");
    #1 check(out_head == 32'h700, "R13 out head", out_head, 32'h700);
    @(negedge clk); out_pop = 1'b1; @(posedge clk); #1 out_pop = 1'b0;
    check(out_head == 32'h701, "R13 out pop shifts", out_head, 32'h701);
    for (int i = 0; i < DEPTH; i++) push_out(32'h800 + i);
    rd_chk(8'hB8, 32'h8000_0000 | DEPTH, "R5 out full");
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk); out_pop = 1'b1; @(posedge clk); #1 out_pop = 1'b0;
    end
    check(out_head == MK, "R13 out empty marker", out_head, MK);
    rd_chk(8'hB8, 32'h4000_0000, "R5 out empty");

    // R12 reset mid-run
    push_in(32'h900);
    acc(1'b1, 8'h9C, 32'h1, r, b);
    do_reset();
    rd_chk(8'h98, 32'h4000_0000, "R12 reset clears queue");
    rd_chk(8'h9C, 32'h0, "R12 reset clears config");
    rd_chk(8'h90, MK, "R12 reset marker");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule